// File: doc/BRIEF.md
# DDR3 Power-Down Sequencer

This block sits on the controller side of a DDR3 interface and decides when the memory may drop its clock enable to save power, and when it must come back. An upstream scheduler pulses an idle request when it has nothing to issue. The sequencer waits until no mode-register, calibration, DLL-lock or data-burst activity is in progress, then lowers CKE while forcing the command bus to NOP/Deselect. It classifies the resulting state from the bank status and the DLL-off mode bit as active, precharge with fast exit, or precharge with slow exit.

A wake pulse brings the device back. So does an internal bound on how long the device may stay down, derived from the refresh interval. After CKE rises, two ready flags tell the scheduler when ordinary commands may go out and when commands that rely on the DLL may go out. The DLL-dependent flag waits longer after a slow exit. Every timing value is a cycle count held in a register that can be reloaded at run time.

Top module: `pdseq_top`

## Requirements
- R1: Out of reset `cke`=1, `cmdReady`=1, `dllCmdReady`=1, `cmdGate`=0, `pdKind`=0. The timing registers hold their parameter defaults.
- R2: `cke` falls only at a clock edge where an idle request is pending (the `idleReq` pulse in that cycle or one held from earlier) and every bit of `busyVec` is 0. `cke` stays 1 otherwise.
- R3: `busyVec` bit 0 = mode register set, bit 1 = MPR access, bit 2 = ZQ calibration, bit 3 = DLL locking, bit 4 = read/write burst. An idle request seen while any bit is 1 is kept, and `cke` falls at the edge that ends the first cycle with all bits 0.
- R4: `cmdGate` is 1 in the first cycle with `cke` low and in the following tCPDED cycles. It is also 1 whenever `cmdReady` is 0.
- R5: Once `cke` changes level it keeps that level for at least tCKE cycles. Entry and exit are both delayed until this holds.
- R6: `pdKind` encodes the power-down type while `cke` is low: 1 = active (any `bankOpen` bit set), 2 = precharge fast exit (no bank open, `dllFastPd`=1), 3 = precharge slow exit (no bank open, `dllFastPd`=0). It reads 0 while `cke` is high.
- R7: If `rowBusy` is 1 when `cke` falls, `pdKind` reads 0 until the first cycle `rowBusy` is 0. It is then classified from `bankOpen` and `dllFastPd` as sampled in that cycle.
- R8: A `wakeReq` pulse while down raises `cke` once R5 allows. `cmdReady` goes to 1 exactly tXP cycles after the first cycle with `cke` high.
- R9: After a slow exit, `dllCmdReady` goes to 1 max(tXP, tXPDLL) cycles after the first cycle with `cke` high. After any other exit it rises together with `cmdReady`.
- R10: Without a wake request, `cke` stays low for at most 9*tREFI-1 cycles, given tCKE does not exceed that.
- R11: A `cfgLoad` pulse writes all five timing registers at the next edge. Timings already counting keep their loaded values, and the next entry or exit uses the new ones.
- R12: A `wakeReq` while `cke` is high cancels a pending idle request. An `idleReq` while `cke` is low is ignored, so no re-entry follows an exit without a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idleReq | input | 1 | Pulse requesting power-down |
| wakeReq | input | 1 | Pulse requesting power-down exit |
| busyVec | input | NBUSY | Operations that forbid entry (bit map in R3) |
| rowBusy | input | 1 | Activate/precharge/refresh still completing |
| bankOpen | input | NBANK | One bit per bank, 1 = row open |
| dllFastPd | input | 1 | Mode bit: 1 keeps DLL on in precharge power-down |
| cfgLoad | input | 1 | Load all timing registers |
| cfgXp | input | TW | tXP in cycles |
| cfgXpdll | input | TW | tXPDLL in cycles |
| cfgCke | input | TW | tCKE in cycles |
| cfgCpded | input | TW | tCPDED in cycles |
| cfgRefi | input | REFW | tREFI in cycles |
| cke | output | 1 | Clock enable to the device |
| cmdGate | output | 1 | 1 = only NOP/Deselect may be driven |
| cmdReady | output | 1 | Ordinary commands permitted |
| dllCmdReady | output | 1 | Reads and ODT control permitted |
| pdKind | output | 2 | Power-down type (encoding in R6) |

## Verification
Entry is tried with an open bank, with all banks closed under both settings of the DLL mode bit, and with row operations still settling. Together these show that the type is chosen from the state at settling and not at CKE fall, and that only the slow type stretches the DLL-dependent wait. Each busy bit is raised in turn around a request to show that every one blocks entry and that the request survives until it clears. A run with no wake shows the refresh-derived bound, and a run after reloading the timing registers shows that every countdown follows the new values rather than the defaults.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [1:0] {
    PD_NONE     = 2'd0,
    PD_ACTIVE   = 2'd1,
    PD_PRE_FAST = 2'd2,
    PD_PRE_SLOW = 2'd3
  } pdKind_e;

  // control -> datapath strobes
  typedef struct packed {
    logic enterStb;
    logic exitStb;
    logic exitSlow;
  } pdStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic ckeHoldOk;
    logic xpDone;
    logic limitHit;
  } pdStatus_t;

  function automatic pdKind_e classifyKind(input logic anyOpen, input logic dllFast);
    if (anyOpen)      return PD_ACTIVE;
    else if (dllFast) return PD_PRE_FAST;
    else              return PD_PRE_SLOW;
  endfunction

endpackage

// File: rtl/pdseq_downcnt.sv
module pdseq_downcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         load,
  input  logic [W-1:0] loadVal,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          cnt <= '0;
    else if (load)      cnt <= loadVal;
    else if (cnt != '0) cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/pdseq_timers.sv
module pdseq_timers
  import pdseq_pkg::*;
#(
  parameter int TW        = 8,
  parameter int REFW      = 16,
  parameter int XP_RST    = 3,
  parameter int XPDLL_RST = 10,
  parameter int CKE_RST   = 3,
  parameter int CPDED_RST = 1,
  parameter int REFI_RST  = 100
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgLoad,
  input  logic [TW-1:0]   cfgXp,
  input  logic [TW-1:0]   cfgXpdll,
  input  logic [TW-1:0]   cfgCke,
  input  logic [TW-1:0]   cfgCpded,
  input  logic [REFW-1:0] cfgRefi,
  input  pdStrobe_t       stb,
  input  logic            ckeLvl,
  output pdStatus_t       status,
  output logic            cmdReady,
  output logic            dllCmdReady,
  output logic            cmdGate
);
  localparam int LW = REFW + 4;   // holds 9 * tREFI
  localparam int CW = TW + 1;     // tCPDED plus the falling cycle

  logic [TW-1:0]   xpReg, xpdllReg, ckeReg, cpdedReg;
  logic [REFW-1:0] refiReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xpReg    <= TW'(XP_RST);
      xpdllReg <= TW'(XPDLL_RST);
      ckeReg   <= TW'(CKE_RST);
      cpdedReg <= TW'(CPDED_RST);
      refiReg  <= REFW'(REFI_RST);
    end else if (cfgLoad) begin
      xpReg    <= cfgXp;
      xpdllReg <= cfgXpdll;
      ckeReg   <= cfgCke;
      cpdedReg <= cfgCpded;
      refiReg  <= cfgRefi;
    end
  end

  logic          toggleStb;
  logic [TW-1:0] ckeLoadVal, dllLoadVal;
  logic [CW-1:0] cpdedLoadVal;
  logic          ckeZero, xpZero, dllZero, cpdedZero;

  assign toggleStb    = stb.enterStb | stb.exitStb;
  assign ckeLoadVal   = (ckeReg == '0) ? '0 : ckeReg - TW'(1);
  assign dllLoadVal   = (stb.exitSlow && (xpdllReg > xpReg)) ? xpdllReg : xpReg;
  assign cpdedLoadVal = {1'b0, cpdedReg} + CW'(1);

  pdseq_downcnt #(.W(TW)) uCkeHold (
    .clk(clk), .rstN(rstN), .load(toggleStb), .loadVal(ckeLoadVal), .zero(ckeZero));
  pdseq_downcnt #(.W(TW)) uXp (
    .clk(clk), .rstN(rstN), .load(stb.exitStb), .loadVal(xpReg), .zero(xpZero));
  pdseq_downcnt #(.W(TW)) uXpDll (
    .clk(clk), .rstN(rstN), .load(stb.exitStb), .loadVal(dllLoadVal), .zero(dllZero));
  pdseq_downcnt #(.W(CW)) uCpded (
    .clk(clk), .rstN(rstN), .load(stb.enterStb), .loadVal(cpdedLoadVal), .zero(cpdedZero));

  // cycles spent with CKE low, saturating
  logic [LW-1:0] pdCnt, nineRefi, limitVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         pdCnt <= '0;
    else if (stb.enterStb)             pdCnt <= LW'(1);
    else if (!ckeLvl && (pdCnt != '1)) pdCnt <= pdCnt + LW'(1);
  end

  assign nineRefi = (LW'(refiReg) << 3) + LW'(refiReg);
  assign limitVal = (nineRefi > LW'(1)) ? nineRefi - LW'(1) : LW'(1);

  assign status.ckeHoldOk = ckeZero;
  assign status.xpDone    = xpZero;
  assign status.limitHit  = !ckeLvl && (pdCnt >= limitVal);

  assign cmdReady    = ckeLvl && xpZero;
  assign dllCmdReady = ckeLvl && dllZero;
  assign cmdGate     = !cmdReady || !cpdedZero;

  // R5: level is frozen while the hold counter runs
  p_cke_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !ckeZero |=> (ckeLvl == $past(ckeLvl)))
    else $error("cke toggled inside tCKE window");

  // R4: bus is gated in the falling cycle
  p_gate_on_fall_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeLvl) |-> cmdGate)
    else $error("command gate open at cke fall");

  // R8: no command right as cke rises when tXP is nonzero
  p_xp_wait_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ckeLvl) && ($past(xpReg) != '0)) |-> !cmdReady)
    else $error("command ready before tXP");

  // R9: DLL-dependent commands never ahead of ordinary ones
  p_dll_after_cmd_r9: assert property (@(posedge clk) disable iff (!rstN)
    dllCmdReady |-> cmdReady)
    else $error("dll ready ahead of command ready");
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
#(
  parameter int NBUSY = 5,
  parameter int NBANK = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idleReq,
  input  logic             wakeReq,
  input  logic [NBUSY-1:0] busyVec,
  input  logic             rowBusy,
  input  logic [NBANK-1:0] bankOpen,
  input  logic             dllFastPd,
  input  pdStatus_t        status,
  output pdStrobe_t        stb,
  output logic             ckeLvl,
  output pdKind_e          kindReg
);
  logic    idlePend, wakePend;
  logic    anyBusy, pendNow, wakeNow, enterNow, exitNow;
  pdKind_e kindNow;

  assign anyBusy = |busyVec;
  assign kindNow = classifyKind(|bankOpen, dllFastPd);
  assign pendNow = (idlePend | idleReq) & ~wakeReq;
  assign wakeNow = wakePend | wakeReq;

  assign enterNow = ckeLvl && pendNow && !anyBusy && status.ckeHoldOk && status.xpDone;
  assign exitNow  = !ckeLvl && (wakeNow || status.limitHit) && status.ckeHoldOk;

  assign stb.enterStb = enterNow;
  assign stb.exitStb  = exitNow;
  assign stb.exitSlow = (kindReg == PD_PRE_SLOW) ||
                        ((kindReg == PD_NONE) && (kindNow == PD_PRE_SLOW));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckeLvl   <= 1'b1;
      idlePend <= 1'b0;
      wakePend <= 1'b0;
      kindReg  <= PD_NONE;
    end else if (ckeLvl) begin
      wakePend <= 1'b0;
      if (enterNow) begin
        ckeLvl   <= 1'b0;
        idlePend <= 1'b0;
        kindReg  <= rowBusy ? PD_NONE : kindNow;
      end else begin
        idlePend <= pendNow;
      end
    end else begin
      if (exitNow) begin
        ckeLvl   <= 1'b1;
        wakePend <= 1'b0;
        idlePend <= 1'b0;
        kindReg  <= PD_NONE;
      end else begin
        wakePend <= wakeNow;
        if ((kindReg == PD_NONE) && !rowBusy) kindReg <= kindNow;
      end
    end
  end

  // R2/R3: never fall while something blocking was in progress
  p_entry_not_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ckeLvl) |-> ($past(anyBusy) == 1'b0))
    else $error("entry during blocking operation");

  // R6: type reads zero while cke is high
  p_kind_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    ckeLvl |-> (kindReg == PD_NONE))
    else $error("kind set with cke high");
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
  import pdseq_pkg::*;
#(
  parameter int NBUSY     = 5,
  parameter int NBANK     = 8,
  parameter int TW        = 8,
  parameter int REFW      = 16,
  parameter int XP_RST    = 3,
  parameter int XPDLL_RST = 10,
  parameter int CKE_RST   = 3,
  parameter int CPDED_RST = 1,
  parameter int REFI_RST  = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idleReq,
  input  logic             wakeReq,
  input  logic [NBUSY-1:0] busyVec,
  input  logic             rowBusy,
  input  logic [NBANK-1:0] bankOpen,
  input  logic             dllFastPd,
  input  logic             cfgLoad,
  input  logic [TW-1:0]    cfgXp,
  input  logic [TW-1:0]    cfgXpdll,
  input  logic [TW-1:0]    cfgCke,
  input  logic [TW-1:0]    cfgCpded,
  input  logic [REFW-1:0]  cfgRefi,
  output logic             cke,
  output logic             cmdGate,
  output logic             cmdReady,
  output logic             dllCmdReady,
  output logic [1:0]       pdKind
);
  pdStrobe_t stb;
  pdStatus_t status;
  logic      ckeLvl;
  pdKind_e   kindReg;

  pdseq_fsm #(.NBUSY(NBUSY), .NBANK(NBANK)) uFsm (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .wakeReq(wakeReq),
    .busyVec(busyVec), .rowBusy(rowBusy), .bankOpen(bankOpen),
    .dllFastPd(dllFastPd), .status(status), .stb(stb),
    .ckeLvl(ckeLvl), .kindReg(kindReg));

  pdseq_timers #(
    .TW(TW), .REFW(REFW), .XP_RST(XP_RST), .XPDLL_RST(XPDLL_RST),
    .CKE_RST(CKE_RST), .CPDED_RST(CPDED_RST), .REFI_RST(REFI_RST)
  ) uTimers (
    .clk(clk), .rstN(rstN), .cfgLoad(cfgLoad), .cfgXp(cfgXp),
    .cfgXpdll(cfgXpdll), .cfgCke(cfgCke), .cfgCpded(cfgCpded),
    .cfgRefi(cfgRefi), .stb(stb), .ckeLvl(ckeLvl), .status(status),
    .cmdReady(cmdReady), .dllCmdReady(dllCmdReady), .cmdGate(cmdGate));

  assign cke    = ckeLvl;
  assign pdKind = kindReg;
endmodule

// File: tb/pdseq_top_test.sv
`timescale 1ns/1ps
module pdseq_top_test;
  logic clk = 0;
  logic rstN = 0;
  logic idleReq = 0, wakeReq = 0, rowBusy = 0, dllFastPd = 1, cfgLoad = 0;
  logic [4:0] busyVec = '0;
  logic [7:0] bankOpen = '0;
  logic [7:0] cfgXp = 3, cfgXpdll = 10, cfgCke = 3, cfgCpded = 1;
  logic [15:0] cfgRefi = 100;
  logic cke, cmdGate, cmdReady, dllCmdReady;
  logic [1:0] pdKind;

  int checks = 0, fails = 0, wd = 0;
  bit done = 0, running = 0;

  always #5 clk = ~clk;

  pdseq_top uut (
    .clk(clk), .rstN(rstN), .idleReq(idleReq), .wakeReq(wakeReq),
    .busyVec(busyVec), .rowBusy(rowBusy), .bankOpen(bankOpen),
    .dllFastPd(dllFastPd), .cfgLoad(cfgLoad), .cfgXp(cfgXp),
    .cfgXpdll(cfgXpdll), .cfgCke(cfgCke), .cfgCpded(cfgCpded),
    .cfgRefi(cfgRefi), .cke(cke), .cmdGate(cmdGate), .cmdReady(cmdReady),
    .dllCmdReady(dllCmdReady), .pdKind(pdKind));

  // ---------------- behavioural reference (time-stamp based) ----------------
  int cyc, tTog, tExit, tEnt;
  int ckeUsed, xpUsed, dllUsed, cpdedUsed;
  int mXp, mXpdll, mCkeT, mCpded, mRefi;
  bit mCke, mIdle, mWake;
  int mKind;

  function automatic int kindOf(input logic [7:0] b, input logic fast);
    if (b != 0) return 1;
    return fast ? 2 : 3;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; tTog = -1000; tExit = -1000; tEnt = -1000;
      ckeUsed = 0; xpUsed = 0; dllUsed = 0; cpdedUsed = 0;
      mXp = 3; mXpdll = 10; mCkeT = 3; mCpded = 1; mRefi = 100;
      mCke = 1; mIdle = 0; mWake = 0; mKind = 0;
    end else begin
      int e, lowCnt, lim, kNow;
      bit holdOk, xpOk, pendNow, wakeNow, slow;
      e = cyc + 1;
      holdOk = (e - tTog) >= ckeUsed;
      xpOk = (cyc - tExit) >= xpUsed;
      lowCnt = cyc - tEnt + 1;
      lim = 9 * mRefi - 1;
      if (lim < 1) lim = 1;
      kNow = kindOf(bankOpen, dllFastPd);
      pendNow = (mIdle || idleReq) && !wakeReq;
      wakeNow = mWake || wakeReq;
      if (mCke) begin
        mWake = 0;
        if (pendNow && busyVec == 0 && holdOk && xpOk) begin
          mCke = 0; tTog = e; ckeUsed = mCkeT; tEnt = e; cpdedUsed = mCpded;
          mIdle = 0; mKind = rowBusy ? 0 : kNow;
        end else mIdle = pendNow;
      end else begin
        if ((wakeNow || lowCnt >= lim) && holdOk) begin
          slow = (mKind == 3) || (mKind == 0 && kNow == 3);
          mCke = 1; tTog = e; ckeUsed = mCkeT; tExit = e; xpUsed = mXp;
          dllUsed = (slow && mXpdll > mXp) ? mXpdll : mXp;
          mKind = 0; mWake = 0; mIdle = 0;
        end else begin
          mWake = wakeNow;
          if (mKind == 0 && !rowBusy) mKind = kNow;
        end
      end
      if (cfgLoad) begin
        mXp = cfgXp; mXpdll = cfgXpdll; mCkeT = cfgCke; mCpded = cfgCpded; mRefi = cfgRefi;
      end
      cyc = e;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && running) begin
      bit rdy, drdy, gate;
      rdy  = mCke && ((cyc - tExit) >= xpUsed);
      drdy = mCke && ((cyc - tExit) >= dllUsed);
      gate = !rdy || ((cyc - tEnt) <= cpdedUsed);
      chk("R5 cke", int'(cke), int'(mCke));
      chk("R8 cmdReady", int'(cmdReady), int'(rdy));
      chk("R9 dllCmdReady", int'(dllCmdReady), int'(drdy));
      chk("R4 cmdGate", int'(cmdGate), int'(gate));
      chk("R6 pdKind", int'(pdKind), mKind);
    end
  end

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      fails++;
      $display("FAIL R1 watchdog: actual=running expected=finished");
      finishRun();
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseIdle();
    idleReq = 1; tick(1); idleReq = 0;
  endtask

  task automatic pulseWake();
    wakeReq = 1; tick(1); wakeReq = 0;
  endtask

  task automatic runPd(input int stay);
    pulseIdle(); tick(stay); pulseWake(); tick(25);
  endtask

  initial begin
    tick(3);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cke", int'(cke), 1);
    chk("R1 cmdReady", int'(cmdReady), 1);
    chk("R1 dllCmdReady", int'(dllCmdReady), 1);
    chk("R1 cmdGate", int'(cmdGate), 0);
    chk("R1 pdKind", int'(pdKind), 0);
    running = 1;
    tick(5);

    // R6 active, then R2 fall after request
    bankOpen = 8'h04;
    pulseIdle();
    chk("R2 cke falls after request", int'(cke), 0);
    tick(8); pulseWake(); tick(25);
    // precharge fast, precharge slow (R9)
    bankOpen = 0; dllFastPd = 1; runPd(6);
    dllFastPd = 0; runPd(6);

    // R3 each blocking bit holds the request
    for (int b = 0; b < 5; b++) begin
      busyVec = 5'(1 << b);
      pulseIdle(); tick(4);
      chk("R3 held while busy", int'(cke), 1);
      busyVec = 0; tick(1);
      chk("R3 entry after busy clears", int'(cke), 0);
      tick(5); pulseWake(); tick(25);
    end

    // R7 row ops settling
    bankOpen = 8'h01; rowBusy = 1; dllFastPd = 0;
    pulseIdle(); tick(2);
    chk("R7 unsettled kind", int'(pdKind), 0);
    bankOpen = 0; rowBusy = 0; tick(1);
    chk("R7 settled kind", int'(pdKind), 3);
    tick(4); pulseWake(); tick(25);

    // R12 wake cancels pending idle, idle while down ignored
    busyVec = 5'b00001;
    idleReq = 1; wakeReq = 1; tick(1); idleReq = 0; wakeReq = 0;
    tick(3); busyVec = 0; tick(4);
    chk("R12 cancelled request", int'(cke), 1);
    pulseIdle(); tick(4); pulseIdle(); tick(2); pulseWake(); tick(20);
    chk("R12 no re-entry", int'(cke), 1);

    // R10 forced exit
    cfgRefi = 4; cfgLoad = 1; tick(1); cfgLoad = 0; tick(2);
    bankOpen = 8'h80;
    pulseIdle();
    begin
      int low = 0;
      while (!cke && low < 200) begin low++; tick(1); end
      chk("R10 low cycles", low, 35);
    end
    tick(20);

    // R11 new timing values
    cfgXp = 6; cfgXpdll = 15; cfgCke = 5; cfgCpded = 4; cfgRefi = 100;
    cfgLoad = 1; tick(1); cfgLoad = 0; tick(3);
    bankOpen = 0; dllFastPd = 0;
    pulseIdle(); tick(7); pulseWake();
    begin
      int n = 0;
      while (!cke) tick(1);
      while (!cmdReady && n < 100) begin tick(1); n++; end
      chk("R11 reloaded tXP", n, 6);
    end
    tick(30);
    dllFastPd = 1; bankOpen = 8'h10; runPd(3);

    running = 0;
    tick(2);
    finishRun();
  end
endmodule